// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single requests from a host into timed bus cycles on an 8-bit raw NAND flash interface. The host chooses a cycle kind, puts up a write word and pulses `start`. The sequencer then runs the cycle kind on the flash pins: a command latch, an address latch, a data write or a data read. Every cycle has three phases. A setup phase comes first, with the latch lines and data bus settled. The strobe-active phase follows, with nWE or nRE low. A hold phase comes last. The length of each phase is a programmable count of clocks.

A data transfer can be one byte or one 32-bit word. A word runs as four back-to-back byte cycles, lowest byte lane first. Host software sends a transfer whose length is not a multiple of four as words followed by single-byte requests. The flash chip-enable is driven from one select bit. The flash ready/busy pin is brought into the clock domain and shown as a status bit.

Top module: `nand_seq`

## Requirements
- R1: Each phase lasts (field + 1) clocks, where the field is the value held in its timing register. A field of 0 gives a one-clock phase. The setup clocks are counted while busy, before the strobe first goes low.
- R2: The strobe-active and hold fields are 3 bits wide, giving 1 to 8 clocks. The setup field is `SETUP_W` bits wide. The default of 2 gives 1 to 4 clocks, and 3 gives 1 to 8.
- R3: After reset, and before any timing write, every phase runs at its maximum length. With the default widths this is 4 setup, 8 strobe and 8 hold clocks.
- R4: A cycle kind of 0 (command) holds CLE high and ALE low for the whole cycle, drives the byte on the data bus, and pulses nWE low during the strobe phase.
- R5: A cycle kind of 1 (address) holds ALE high and CLE low for the whole cycle, and pulses nWE low during the strobe phase.
- R6: A cycle kind of 2 (data write) keeps CLE and ALE low, drives the data bus for the whole cycle, and pulses nWE low during the strobe phase.
- R7: A cycle kind of 3 (data read) pulses nRE low during the strobe phase and does not drive the data bus. It captures the flash byte on the last strobe clock.
- R8: With `word_mode` at 1, a request runs four byte cycles. Lane 0 (bits 7:0) goes first, up to lane 3 (bits 31:24). Read bytes land in the same lanes. With `word_mode` at 0, a single cycle uses lane 0, and a read returns zero in bits 31:8.
- R9: Writing the select bit sets nCE: a 1 drives nCE high (deasserted) and a 0 drives it low. After reset nCE is high.
- R10: `status_ready` follows the ready/busy pin (1 = ready) through two flip-flops, so it changes on the second clock edge after the pin. It is 0 after reset.
- R11: A `start` pulse while `busy` is high has no effect. `done` is high for exactly one clock, starting in the cycle after the last hold clock of the request, which is the same cycle in which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the three timing fields |
| cfg_setup | input | SETUP_W | Setup clocks minus one |
| cfg_strobe | input | STROBE_W | Strobe-active clocks minus one |
| cfg_hold | input | STROBE_W | Hold clocks minus one |
| ce_we | input | 1 | Load the chip-select bit |
| ce_off | input | 1 | Select bit value: 1 = nCE high, 0 = nCE low |
| start | input | 1 | Begin a request when idle |
| op | input | 2 | Cycle kind: 0 command, 1 address, 2 write, 3 read |
| word_mode | input | 1 | 1 = four byte cycles, 0 = one byte cycle |
| wdata | input | 32 | Write bytes, lane 0 in bits 7:0 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock end-of-request pulse |
| rdata | output | 32 | Bytes captured by read cycles |
| status_ready | output | 1 | Synchronised ready/busy (1 = ready) |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb | input | 1 | Ready/busy pin, 1 = ready |

## Verification
Some properties hold on every clock, and the assertions watch these continuously:
- the two strobes are never low together;
- CLE and ALE are never high together;
- `done` never lasts longer than one clock;
- a busy-time `start` leaves the latched request unchanged;
- the phase sequence leaves idle only through setup;
- a byte request never advances the byte lane;
- the select bit reaches nCE one clock after it is written;
- a rising status bit matches the pin two clocks earlier.

Only the bench scenarios can show the following:
- exact phase lengths for each timing setting, including the reset defaults;
- the lane order of word transfers;
- the read byte captured at the right point of the strobe;
- the total cycle count of a request that was hit by an ignored `start`.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_WR   = 2'd2,
        OP_RD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic cle;
        logic ale;
        logic we_n;
        logic re_n;
        logic oe;
    } pins_t;

    function automatic pins_t decode_pins(phase_e ph, op_e op);
        pins_t p;
        logic active;
        active = (ph != PH_IDLE);
        p.cle  = active && (op == OP_CMD);
        p.ale  = active && (op == OP_ADDR);
        p.we_n = !((ph == PH_STROBE) && (op != OP_RD));
        p.re_n = !((ph == PH_STROBE) && (op == OP_RD));
        p.oe   = active && (op != OP_RD);
        return p;
    endfunction

endpackage

// File: rtl/nand_seq_sync.sv
module nand_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];

    assert_sync_delay_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_out) |-> $past(async_in, 2));

endmodule

// File: rtl/nand_seq_phase.sv
module nand_seq_phase
    import nand_seq_pkg::*;
#(
    parameter int SETUP_W  = 2,
    parameter int STROBE_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                more,
    input  logic [SETUP_W-1:0]  setup_len,
    input  logic [STROBE_W-1:0] strobe_len,
    input  logic [STROBE_W-1:0] hold_len,
    output phase_e              phase,
    output logic                strobe_last,
    output logic                byte_end
);
    localparam int CNT_W = (SETUP_W > STROBE_W) ? SETUP_W : STROBE_W;

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: if (go) begin
                    ph_q  <= PH_SETUP;
                    cnt_q <= CNT_W'(setup_len);
                end
                PH_SETUP: if (cnt_zero) begin
                    ph_q  <= PH_STROBE;
                    cnt_q <= CNT_W'(strobe_len);
                end else cnt_q <= cnt_q - 1'b1;
                PH_STROBE: if (cnt_zero) begin
                    ph_q  <= PH_HOLD;
                    cnt_q <= CNT_W'(hold_len);
                end else cnt_q <= cnt_q - 1'b1;
                PH_HOLD: if (cnt_zero) begin
                    if (more) begin
                        ph_q  <= PH_SETUP;
                        cnt_q <= CNT_W'(setup_len);
                    end else begin
                        ph_q <= PH_IDLE;
                    end
                end else cnt_q <= cnt_q - 1'b1;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign phase       = ph_q;
    assign strobe_last = (ph_q == PH_STROBE) && cnt_zero;
    assign byte_end    = (ph_q == PH_HOLD) && cnt_zero;

    assert_leave_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_IDLE) |=> (ph_q == PH_IDLE || ph_q == PH_SETUP));

endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int SETUP_W  = 2,
    parameter int STROBE_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [SETUP_W-1:0]  cfg_setup,
    input  logic [STROBE_W-1:0] cfg_strobe,
    input  logic [STROBE_W-1:0] cfg_hold,
    input  logic                ce_we,
    input  logic                ce_off,
    input  logic                start,
    input  logic [1:0]          op,
    input  logic                word_mode,
    input  logic [31:0]         wdata,
    output logic                busy,
    output logic                done,
    output logic [31:0]         rdata,
    output logic                status_ready,
    output logic                nand_cle,
    output logic                nand_ale,
    output logic                nand_we_n,
    output logic                nand_re_n,
    output logic                nand_ce_n,
    output logic [7:0]          nand_dq_o,
    output logic                nand_dq_oe,
    input  logic [7:0]          nand_dq_i,
    input  logic                nand_rb
);
    localparam int LANES = 4;
    localparam int IDX_W = $clog2(LANES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

    logic [SETUP_W-1:0]  setup_q;
    logic [STROBE_W-1:0] strobe_q, hold_q;
    logic                ce_off_q;
    op_e                 op_q;
    logic                word_q;
    logic [31:0]         wdata_q, rdata_q;
    logic [IDX_W-1:0]    idx_q;
    logic                done_q;
    phase_e              phase;
    logic                strobe_last, byte_end, go, more;
    pins_t               pins;

    assign go   = start && (phase == PH_IDLE);
    assign more = word_q && (idx_q != LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q  <= '1;
            strobe_q <= '1;
            hold_q   <= '1;
            ce_off_q <= 1'b1;
        end else begin
            if (cfg_we) begin
                setup_q  <= cfg_setup;
                strobe_q <= cfg_strobe;
                hold_q   <= cfg_hold;
            end
            if (ce_we) ce_off_q <= ce_off;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_CMD;
            word_q  <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= byte_end && !more;
            if (go) begin
                op_q    <= op_e'(op);
                word_q  <= word_mode;
                wdata_q <= wdata;
                rdata_q <= '0;
                idx_q   <= '0;
            end else begin
                if (strobe_last && op_q == OP_RD)
                    rdata_q[{idx_q, 3'b000} +: 8] <= nand_dq_i;
                if (byte_end && more)
                    idx_q <= idx_q + 1'b1;
            end
        end
    end

    nand_seq_phase #(.SETUP_W(SETUP_W), .STROBE_W(STROBE_W)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .more       (more),
        .setup_len  (setup_q),
        .strobe_len (strobe_q),
        .hold_len   (hold_q),
        .phase      (phase),
        .strobe_last(strobe_last),
        .byte_end   (byte_end)
    );

    nand_seq_sync #(.STAGES(2)) u_rb_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in(nand_rb),
        .sync_out(status_ready)
    );

    assign pins       = decode_pins(phase, op_q);
    assign nand_cle   = pins.cle;
    assign nand_ale   = pins.ale;
    assign nand_we_n  = pins.we_n;
    assign nand_re_n  = pins.re_n;
    assign nand_dq_oe = pins.oe;
    assign nand_dq_o  = wdata_q[{idx_q, 3'b000} +: 8];
    assign nand_ce_n  = ce_off_q;
    assign busy       = (phase != PH_IDLE);
    assign done       = done_q;
    assign rdata      = rdata_q;

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));
    assert_latch_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(op_q) && $stable(wdata_q)));
    assert_byte_lane_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !word_q) |-> (idx_q == '0));
    assert_ce_select_R9: assert property (@(posedge clk) disable iff (rst)
        ce_we |=> (nand_ce_n == $past(ce_off)));

endmodule

// File: tb/tb_nand_seq.sv
module tb_nand_seq;
    localparam int N_VEC = 6;
    // op[43:42] word[41] setup[40:38] strobe[37:35] hold[34:32] data[31:0]
    localparam logic [43:0] VEC [N_VEC] = '{
        {2'd0, 1'b0, 3'd0, 3'd0, 3'd0, 32'h0000_0070},
        {2'd1, 1'b0, 3'd1, 3'd2, 3'd3, 32'h0000_005A},
        {2'd2, 1'b1, 3'd0, 3'd1, 3'd0, 32'h4433_2211},
        {2'd3, 1'b1, 3'd2, 3'd0, 3'd1, 32'h0000_0000},
        {2'd3, 1'b0, 3'd3, 3'd7, 3'd2, 32'h0000_0000},
        {2'd2, 1'b0, 3'd3, 3'd3, 3'd7, 32'hFFFF_FFEE}
    };
    localparam logic [31:0] RD_PAT = 32'hD4C3_B2A1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_setup = '0;
    logic [2:0]  cfg_strobe = '0, cfg_hold = '0;
    logic        ce_we = 1'b0, ce_off = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic        word_mode = 1'b0;
    logic [31:0] wdata = '0;
    logic [7:0]  nand_dq_i = '0;
    logic        nand_rb = 1'b0;
    logic        busy, done, status_ready, nand_cle, nand_ale;
    logic        nand_we_n, nand_re_n, nand_ce_n, nand_dq_oe;
    logic [31:0] rdata;
    logic [7:0]  nand_dq_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nand_seq dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_setup(cfg_setup),
        .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .ce_we(ce_we),
        .ce_off(ce_off), .start(start), .op(op), .word_mode(word_mode),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
        .status_ready(status_ready), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
        .nand_rb(nand_rb)
    );

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int s, input int t, input int h);
        cfg_we = 1'b1; cfg_setup = 2'(s); cfg_strobe = 3'(t); cfg_hold = 3'(h);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one request and checks its timing and pins; restart_at > 0 raises start mid-cycle.
    task automatic run_op(input logic [1:0] o, input logic w, input logic [31:0] d,
                          input int s, input int t, input int h, input int restart_at);
        int nb, busy_n, first_setup, first_strobe, strobes, pin_err, lane_err, done_err, k;
        logic seen, prev, now;
        nb = w ? 4 : 1;
        busy_n = 0; first_setup = 0; first_strobe = 0; strobes = 0;
        pin_err = 0; lane_err = 0; done_err = 0; k = 0;
        seen = 1'b0; prev = 1'b0;
        nand_dq_i = RD_PAT[7:0];
        start = 1'b1; op = o; word_mode = w; wdata = d;
        @(negedge clk);
        start = 1'b0;
        while (busy && busy_n < 5000) begin
            busy_n++;
            if (busy_n == restart_at) begin
                start = 1'b1; op = 2'd2; word_mode = 1'b1; wdata = 32'hDEAD_BEEF;
            end else if (busy_n == restart_at + 1) begin
                start = 1'b0;
            end
            now = (o == 2'd3) ? !nand_re_n : !nand_we_n;
            if (!seen && !now) first_setup++;
            if (now) begin
                if (!prev) strobes++;
                if (strobes == 1) first_strobe++;
                seen = 1'b1;
                if (o != 2'd3 && nand_dq_o != d[8*((strobes-1)&3) +: 8]) lane_err++;
            end
            if (nand_cle != (o == 2'd0) || nand_ale != (o == 2'd1) ||
                nand_dq_oe != (o != 2'd3)) pin_err++;
            if ((o == 2'd3 && !nand_we_n) || (o != 2'd3 && !nand_re_n)) pin_err++;
            if (done) done_err++;
            if (o == 2'd3 && prev && !now) begin
                k++;
                nand_dq_i = RD_PAT[8*(k&3) +: 8];
            end
            prev = now;
            @(negedge clk);
        end
        check(busy_n < 5000, "R11 request ends", busy_n, 0);
        check(first_setup == s + 1, "R1 setup length", first_setup, s + 1);
        check(first_strobe == t + 1, "R1 strobe length", first_strobe, t + 1);
        check(busy_n == nb * (s + t + h + 3), "R1 R8 total busy clocks", busy_n, nb * (s + t + h + 3));
        check(strobes == nb, "R8 byte cycles", strobes, nb);
        check(pin_err == 0, (o == 2'd0) ? "R4 cmd pins" : (o == 2'd1) ? "R5 addr pins" :
              (o == 2'd2) ? "R6 write pins" : "R7 read pins", pin_err, 0);
        if (o != 2'd3) check(lane_err == 0, "R8 lane order out", lane_err, 0);
        check(done_err == 0 && done, "R11 done at end", {done_err, done}, 1);
        if (o == 2'd3)
            check(rdata == (w ? RD_PAT : {24'h0, RD_PAT[7:0]}), "R7 R8 read data",
                  rdata, w ? RD_PAT : {24'h0, RD_PAT[7:0]});
        @(negedge clk);
        check(!done && !busy, "R11 done one clock", {done, busy}, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !busy && !done,
              "R9 reset pins", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, busy, done},
              7'b1110000);
        check(!status_ready, "R10 reset status", status_ready, 0);

        // R3 defaults: 4 / 8 / 8 clocks before any timing write
        run_op(2'd0, 1'b0, 32'h0000_00FF, 3, 7, 7, 0);

        for (int i = 0; i < N_VEC; i++) begin
            set_cfg(int'(VEC[i][40:38]), int'(VEC[i][37:35]), int'(VEC[i][34:32]));
            run_op(VEC[i][43:42], VEC[i][41], VEC[i][31:0],
                   int'(VEC[i][40:38]), int'(VEC[i][37:35]), int'(VEC[i][34:32]), 0);
        end

        // R11: start during a busy command is ignored (same timing, pins, single done)
        set_cfg(1, 1, 1);
        run_op(2'd0, 1'b0, 32'h0000_0090, 1, 1, 1, 2);

        // R2: setup field at its 2-bit maximum with short strobes
        set_cfg(3, 0, 0);
        run_op(2'd1, 1'b1, 32'h0403_0201, 3, 0, 0, 0);

        // R9: chip select bit
        ce_we = 1'b1; ce_off = 1'b0;
        @(negedge clk);
        ce_we = 1'b0;
        check(!nand_ce_n, "R9 select low", nand_ce_n, 0);
        ce_we = 1'b1; ce_off = 1'b1;
        @(negedge clk);
        ce_we = 1'b0;
        check(nand_ce_n, "R9 select high", nand_ce_n, 1);

        // R10: two-flop ready sync
        nand_rb = 1'b1;
        @(negedge clk);
        check(!status_ready, "R10 one edge", status_ready, 0);
        @(negedge clk);
        check(status_ready, "R10 two edges", status_ready, 1);
        nand_rb = 1'b0;
        @(negedge clk);
        check(status_ready, "R10 busy one edge", status_ready, 1);
        @(negedge clk);
        check(!status_ready, "R10 busy two edges", status_ready, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule